// File: doc/BRIEF.md
# Character LCD Nibble-Bus Write Controller

This block drives a character display module that has a parallel command/data controller, using only the upper four of its data lines. After reset it waits for the panel to power up. It then runs a fixed wake-up sequence that leaves the panel's controller in four-bit mode. Next it sends a short configuration burst that sets the line mode, turns the display on, clears it and selects the entry direction. Only then does it accept bytes from a valid/ready stream.

Each accepted byte is split into two nibble transfers, the upper half first. Each nibble is latched onto the bus and then strobed with one enable pulse. A byte flag selects whether the byte is a command or a displayable character. All panel timing comes from an internal 100 µs tick, which divides the clock by a parameter. A short wait is 10 ticks (1 ms) and a long wait is 100 ticks (10 ms). The read/write line stays at write, and the panel's busy flag is never read. The fixed waits take the place of polling.

Back-pressure rules for the input stream are as follows. A byte is taken only on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low from reset until the configuration burst and its final wait have completed. After that it is low from the cycle after an acceptance until both nibbles of that byte and the 1 ms post-byte wait are done. The producer must hold `in_byte` and `in_is_char` steady while `in_valid` is high and `in_ready` is low.

Top module: `lcd4_write_ctrl`

## Requirements
- R1: During and directly after reset, `lcd_e` is 0, `in_ready` is 0 and `lcd_rw` is 0.
- R2: No enable pulse occurs during the first 100 ticks after reset is released (10 ms power-up wait).
- R3: The first four enable pulses carry nibbles 0x3, 0x3, 0x3, 0x2 with `lcd_rs`=0. They are followed by gaps of at least 100, 10, 10 and 10 ticks before the next pulse.
- R4: Pulses 5 to 12 carry the command bytes 0x28, 0x0C, 0x01 and 0x06 with `lcd_rs`=0, each as upper nibble then lower nibble. The clear command (0x01) is followed by at least 100 ticks before the next pulse.
- R5: `in_ready` stays 0 until the 12th pulse has ended and at least 10 ticks have passed after it.
- R6: Every accepted byte produces exactly two pulses: `in_byte[7:4]` first, then `in_byte[3:0]`, both with `lcd_rs` equal to `in_is_char` (0 = command, 1 = character).
- R7: `lcd_e` is high for exactly one tick period per pulse. `lcd_rs` and `lcd_d` do not change during the tick before the rising edge, while `lcd_e` is high, or during the tick after the falling edge.
- R8: After a byte's lower nibble there are at least 10 ticks before the next pulse. `in_ready` is 0 in the cycle after every acceptance and stays 0 until that byte has finished.
- R9: A byte that is offered while `in_ready` is 0 is neither lost nor duplicated: it is sent exactly once after ready rises. `lcd_rw` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered on the stream |
| in_ready | output | 1 | Controller can take a byte this cycle |
| in_byte | input | 8 | Command or character code |
| in_is_char | input | 1 | 1 = character (RS high), 0 = command |
| lcd_rs | output | 1 | Register select to panel |
| lcd_rw | output | 1 | Read/write line, held at write (0) |
| lcd_e | output | 1 | Enable strobe |
| lcd_d | output | 4 | Data lines D4..D7 (bit 0 = D4) |

## Verification
The assertions assume that the nibble engine is started only while it is idle. They also assume that a stream producer keeps its byte and flag steady between raising `in_valid` and the accepting edge. The bench drives inputs only at falling clock edges and keeps `in_valid` high with an unchanged byte from just after reset until it is accepted, which deliberately offers that byte throughout the whole initialization. It also uses a small tick divider, so the 10 ms waits stay short in cycles while every timing rule still applies in units of ticks.

// File: rtl/lcd4_pkg.sv
package lcd4_pkg;

  typedef enum logic [2:0] {
    ENG_IDLE, ENG_SETUP, ENG_PULSE, ENG_HOLD, ENG_WAIT
  } eng_state_t;

  typedef enum logic [1:0] {
    TOP_PWR, TOP_INIT, TOP_STREAM
  } top_state_t;

  typedef enum logic [1:0] {
    WAIT_NONE, WAIT_SHORT, WAIT_LONG
  } wait_sel_t;

  typedef struct packed {
    logic [3:0] nib;
    wait_sel_t  wsel;
  } init_step_t;

  localparam int INIT_STEPS = 12;

  // Wake-up nibbles (steps 0..3) then configuration bytes split high/low (4..11)
  function automatic init_step_t init_step(input logic [3:0] idx);
    init_step_t s;
    case (idx)
      4'd0:    s = '{nib: 4'h3, wsel: WAIT_LONG};
      4'd1:    s = '{nib: 4'h3, wsel: WAIT_SHORT};
      4'd2:    s = '{nib: 4'h3, wsel: WAIT_SHORT};
      4'd3:    s = '{nib: 4'h2, wsel: WAIT_SHORT};
      4'd4:    s = '{nib: 4'h2, wsel: WAIT_NONE};
      4'd5:    s = '{nib: 4'h8, wsel: WAIT_SHORT};
      4'd6:    s = '{nib: 4'h0, wsel: WAIT_NONE};
      4'd7:    s = '{nib: 4'hC, wsel: WAIT_SHORT};
      4'd8:    s = '{nib: 4'h0, wsel: WAIT_NONE};
      4'd9:    s = '{nib: 4'h1, wsel: WAIT_LONG};
      4'd10:   s = '{nib: 4'h0, wsel: WAIT_NONE};
      default: s = '{nib: 4'h6, wsel: WAIT_SHORT};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lcd4_tick_gen.sv
module lcd4_tick_gen #(
  parameter int DIV = 12500
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lcd4_nibble_engine.sv
module lcd4_nibble_engine
  import lcd4_pkg::*;
#(
  parameter int WAIT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic              start_rs,
  input  logic [3:0]        start_nib,
  input  logic [WAIT_W-1:0] start_wait,
  output logic              busy,
  output logic              lcd_rs,
  output logic              lcd_e,
  output logic [3:0]        lcd_d
);
  eng_state_t        st;
  logic              seen;
  logic [WAIT_W-1:0] wq;

  assign busy = (st != ENG_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ENG_IDLE;
      seen   <= 1'b0;
      wq     <= '0;
      lcd_rs <= 1'b0;
      lcd_e  <= 1'b0;
      lcd_d  <= 4'h0;
    end else begin
      case (st)
        ENG_IDLE: if (start) begin
          lcd_rs <= start_rs;
          lcd_d  <= start_nib;
          wq     <= start_wait;
          seen   <= 1'b0;
          st     <= ENG_SETUP;
        end
        ENG_SETUP: if (tick) begin
          // second tick guarantees one full tick of setup
          if (seen) begin
            lcd_e <= 1'b1;
            st    <= ENG_PULSE;
          end else begin
            seen <= 1'b1;
          end
        end
        ENG_PULSE: if (tick) begin
          lcd_e <= 1'b0;
          st    <= ENG_HOLD;
        end
        ENG_HOLD: if (tick) begin
          st <= (wq == '0) ? ENG_IDLE : ENG_WAIT;
        end
        ENG_WAIT: if (tick) begin
          wq <= wq - 1'b1;
          if (wq == WAIT_W'(1)) st <= ENG_IDLE;
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R8
  AST_E_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e != $past(lcd_e)) |-> $past(tick)); // R7
  AST_BUS_STABLE_E_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_e |-> $stable({lcd_rs, lcd_d})); // R7
  AST_BUS_STABLE_E_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> $stable({lcd_rs, lcd_d})); // R7
endmodule

// File: rtl/lcd4_write_ctrl.sv
module lcd4_write_ctrl
  import lcd4_pkg::*;
#(
  parameter int TICK_DIV    = 12500,
  parameter int SHORT_TICKS = 10,
  parameter int LONG_TICKS  = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  input  logic       in_is_char,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [3:0] lcd_d
);
  localparam int WAIT_W = $clog2(LONG_TICKS + 1);

  logic              tick, busy, accept;
  logic              eng_start, eng_rs;
  logic [3:0]        eng_nib;
  logic [WAIT_W-1:0] eng_wait;
  top_state_t        state;
  logic [WAIT_W-1:0] pcnt;
  logic [3:0]        step;
  logic              low_pend, rs_q;
  logic [3:0]        low_q;
  init_step_t        cur;

  assign lcd_rw   = 1'b0;
  assign in_ready = (state == TOP_STREAM) && !busy && !low_pend;
  assign accept   = in_valid && in_ready;
  assign cur      = init_step(step);

  lcd4_tick_gen #(.DIV(TICK_DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  lcd4_nibble_engine #(.WAIT_W(WAIT_W)) eng_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .start(eng_start), .start_rs(eng_rs), .start_nib(eng_nib),
    .start_wait(eng_wait), .busy(busy),
    .lcd_rs(lcd_rs), .lcd_e(lcd_e), .lcd_d(lcd_d)
  );

  always_comb begin
    eng_start = 1'b0;
    eng_rs    = 1'b0;
    eng_nib   = 4'h0;
    eng_wait  = '0;
    case (state)
      TOP_INIT: begin
        eng_start = !busy;
        eng_nib   = cur.nib;
        case (cur.wsel)
          WAIT_SHORT: eng_wait = WAIT_W'(SHORT_TICKS);
          WAIT_LONG:  eng_wait = WAIT_W'(LONG_TICKS);
          default:    eng_wait = '0;
        endcase
      end
      TOP_STREAM: begin
        if (low_pend && !busy) begin
          eng_start = 1'b1;
          eng_rs    = rs_q;
          eng_nib   = low_q;
          eng_wait  = WAIT_W'(SHORT_TICKS);
        end else if (accept) begin
          eng_start = 1'b1;
          eng_rs    = in_is_char;
          eng_nib   = in_byte[7:4];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= TOP_PWR;
      pcnt     <= '0;
      step     <= '0;
      low_pend <= 1'b0;
      rs_q     <= 1'b0;
      low_q    <= 4'h0;
    end else begin
      case (state)
        TOP_PWR: if (tick) begin
          if (pcnt == WAIT_W'(LONG_TICKS - 1)) state <= TOP_INIT;
          else                                 pcnt  <= pcnt + 1'b1;
        end
        TOP_INIT: if (eng_start) begin
          step <= step + 1'b1;
          if (step == 4'(INIT_STEPS - 1)) state <= TOP_STREAM;
        end
        TOP_STREAM: begin
          if (accept) begin
            low_pend <= 1'b1;
            rs_q     <= in_is_char;
            low_q    <= in_byte[3:0];
          end else if (low_pend && !busy) begin
            low_pend <= 1'b0;
          end
        end
        default: state <= TOP_PWR;
      endcase
    end
  end

  AST_READY_ENGINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !lcd_e); // R8
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R8
  AST_HIGH_NIBBLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (lcd_d == $past(in_byte[7:4]) && lcd_rs == $past(in_is_char))); // R6
endmodule

// File: tb/lcd4_write_ctrl_tb.sv
module lcd4_write_ctrl_tb_top;
  localparam int T = 4;
  localparam int NEV = 18;
  // {rs, nibble, minimum ticks of wait after the pulse}
  localparam logic [12:0] VEC [NEV] = '{
    {1'b0, 4'h3, 8'd100}, {1'b0, 4'h3, 8'd10}, {1'b0, 4'h3, 8'd10}, {1'b0, 4'h2, 8'd10},
    {1'b0, 4'h2, 8'd0},   {1'b0, 4'h8, 8'd10}, {1'b0, 4'h0, 8'd0},  {1'b0, 4'hC, 8'd10},
    {1'b0, 4'h0, 8'd0},   {1'b0, 4'h1, 8'd100},{1'b0, 4'h0, 8'd0},  {1'b0, 4'h6, 8'd10},
    {1'b1, 4'h4, 8'd0},   {1'b1, 4'h1, 8'd10}, {1'b0, 4'h8, 8'd0},  {1'b0, 4'h0, 8'd10},
    {1'b1, 4'h6, 8'd0},   {1'b1, 4'h9, 8'd10}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_is_char = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, lcd_rs, lcd_rw, lcd_e;
  logic [3:0] lcd_d;

  always #4 clk = ~clk;

  lcd4_write_ctrl #(.TICK_DIV(T), .SHORT_TICKS(10), .LONG_TICKS(100)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_is_char(in_is_char), .lcd_rs(lcd_rs),
    .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_d(lcd_d)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0, rst_cyc = 0, nev = 0, first_ready = -1;
  int last_fall = -1000, last_chg = -1000, rise_c = 0;
  int rw_bad = 0, setup_bad = 0, hold_bad = 0;
  int ev_rise [32], ev_fall [32], ev_w [32];
  logic [3:0] ev_nib [32];
  logic ev_rs [32];
  logic prev_e = 1'b0;
  logic [4:0] prev_bus = 5'h0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (lcd_rw) rw_bad++;
    if ({lcd_rs, lcd_d} != prev_bus) begin
      if (lcd_e || (cyc - last_fall) < T) hold_bad++;
      last_chg = cyc;
    end
    if (lcd_e && !prev_e) begin
      rise_c = cyc;
      if (cyc - last_chg < T) setup_bad++;
      if (nev < 32) ev_rise[nev] = cyc;
    end
    if (!lcd_e && prev_e && nev < 32) begin
      ev_nib[nev] = lcd_d; ev_rs[nev] = lcd_rs;
      ev_fall[nev] = cyc; ev_w[nev] = cyc - rise_c;
      last_fall = cyc; nev++;
    end
    if (in_ready && first_ready < 0) first_ready = cyc;
    prev_e = lcd_e; prev_bus = {lcd_rs, lcd_d};
  end

  task automatic send(input logic [7:0] b, input logic rs);
    in_byte = b; in_is_char = rs; in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R8 ready after accept", in_ready, 0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(lcd_e == 1'b0,    "R1 e in reset", lcd_e, 0);
    chk(in_ready == 1'b0, "R1 ready in reset", in_ready, 0);
    chk(lcd_rw == 1'b0,   "R1 rw in reset", lcd_rw, 0);
    rst_n = 1'b1; rst_cyc = cyc;
    // R9: offer a character during the whole initialization
    in_byte = 8'h41; in_is_char = 1'b1; in_valid = 1'b1;
    while (nev < 12) @(negedge clk);
    chk(first_ready < 0, "R5 ready during init", first_ready, -1);
    send(8'h41, 1'b1);
    chk(first_ready - ev_fall[11] >= 10 * T, "R5 ready after config wait",
        first_ready - ev_fall[11], 10 * T);
    send(8'h80, 1'b0);
    send(8'h69, 1'b1);
    while (!in_ready) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(nev == NEV, "R9 pulse count", nev, NEV);
    chk(ev_rise[0] - rst_cyc >= 100 * T, "R2 power-up wait", ev_rise[0] - rst_cyc, 100 * T);
    for (int i = 0; i < NEV; i++) begin
      logic [12:0] v;
      string r;
      v = VEC[i];
      r = (i < 4) ? "R3" : (i < 12) ? "R4" : "R6";
      chk({ev_rs[i], ev_nib[i]} == v[12:8], $sformatf("%s pulse %0d rs/nibble", r, i),
          {ev_rs[i], ev_nib[i]}, v[12:8]);
      chk(ev_w[i] == T, $sformatf("R7 pulse %0d width", i), ev_w[i], T);
      if (i + 1 < NEV)
        chk(ev_rise[i+1] - ev_fall[i] >= (int'(v[7:0]) + 1) * T,
            $sformatf("%s gap after pulse %0d (R8)", r, i),
            ev_rise[i+1] - ev_fall[i], (int'(v[7:0]) + 1) * T);
    end
    chk(setup_bad == 0, "R7 setup before rise", setup_bad, 0);
    chk(hold_bad == 0,  "R7 hold after fall", hold_bad, 0);
    chk(rw_bad == 0,    "R9 rw held at write", rw_bad, 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", nev, NEV);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule